// File: doc/BRIEF.md
# Multiplexed Display Dimming Timing Generator

This block is the timing engine that drives a vacuum-fluorescent style display multiplexed over two or three grid phases. It divides the oscillator clock by four to form a bit-time tick, walks through the grid phases, and in each phase drives one grid line for a fixed active window followed by a short blanking gap. In the same phase it gates the segment pins with a programmable on-time, taking the segment pattern from the latch word that belongs to that grid.

The on-time is a 10-bit count of bit times, clamped so that it never runs into the blanking gap. A new value is picked up only at a phase boundary, so the lit time cannot be cut short or stretched in the middle of a phase. A dim-pulse output and two sync outputs repeat the window and the active phase, so that a second driver can follow the same timing.

Top module: `vfd_mux_timer`

## Requirements
- R1: While reset is held, and in the first phase after it, the phase is GRID1, the loaded on-time is 0, every segment output and the dim-pulse output are low, and `grid_o` is 3'b001.
- R2: One bit time is 4 clock cycles and every grid phase lasts 1024 bit times (4096 clocks). Phases after reset start at the clock edges that follow multiples of 4096 clocks.
- R3: Within a phase, the grid bit of the current phase (`grid_o[0]` GRID1, `grid_o[1]` GRID2, `grid_o[2]` GRID3) is high for bit times 0 to 1015 and every grid bit is low for bit times 1016 to 1023. At most one grid bit is high at any time.
- R4: With `duplex_i` = 1 the phases run GRID1, GRID2, GRID1, ... and GRID3 is never entered. With `duplex_i` = 0 they run GRID1, GRID2, GRID3, GRID1, ... The mode is read when a phase ends.
- R5: Segments are lit for the first N bit times of a phase, where N is the loaded on-time. A programmed value above 1016 loads as 1016.
- R6: `dim_i` is loaded only at the end of a phase and takes effect from the first bit time of the next phase. A change in the middle of a phase has no effect on that phase.
- R7: `seg_o` equals the latch word of the current phase (GRID1 `seg_g1_i`, GRID2 `seg_g2_i`, GRID3 `seg_g3_i`) while the on-time window is open, and is all zero while it is closed.
- R8: `dim_pulse_o` is high exactly while the on-time window is open.
- R9: `{sync1_o, sync2_o}` is 2'b10 in the GRID1 active window, 2'b01 in the GRID2 active window, 2'b11 in the GRID3 active window, and 2'b00 in every blanking gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| duplex_i | input | 1 | 1 = two phases, 0 = three phases |
| dim_i | input | 10 | Programmed on-time in bit times per phase |
| seg_g1_i | input | 32 | Segment latch word for GRID1 |
| seg_g2_i | input | 32 | Segment latch word for GRID2 |
| seg_g3_i | input | 32 | Segment latch word for GRID3 |
| seg_o | output | 32 | Gated segment outputs, high = lit |
| grid_o | output | 3 | Grid drive, one-hot, high = active |
| dim_pulse_o | output | 1 | On-time window for a following driver |
| sync1_o | output | 1 | Phase code, upper bit |
| sync2_o | output | 1 | Phase code, lower bit |

## Verification
The bench runs the engine in three-phase mode and then in two-phase mode, with latch words that differ per grid so that a wrong latch choice or a wrong phase order shows at the segment pins. The on-time is taken through zero, a mid value, one, the exact limit 1016 and the top code 1023, which separates a missing clamp from a correct one and places the window edge against the blanking gap. Several on-time changes land in the middle of a phase, which tells an update at the phase boundary apart from an immediate one.

// File: rtl/vfd_mux_pkg.sv
package vfd_mux_pkg;

  typedef enum logic [1:0] {
    PH_G1 = 2'd0,
    PH_G2 = 2'd1,
    PH_G3 = 2'd2
  } phase_e;

  // Phase order: duplex alternates G1/G2, triplex walks G1/G2/G3.
  function automatic phase_e next_phase(input phase_e ph, input logic duplex);
    phase_e nx;
    case (ph)
      PH_G1:   nx = PH_G2;
      PH_G2:   nx = duplex ? PH_G1 : PH_G3;
      default: nx = PH_G1;
    endcase
    return nx;
  endfunction

  // One-hot grid drive for a phase, all zero in the blanking gap.
  function automatic logic [2:0] grid_code(input phase_e ph, input logic on);
    logic [2:0] g;
    g = 3'b000;
    if (on) begin
      case (ph)
        PH_G1:   g = 3'b001;
        PH_G2:   g = 3'b010;
        default: g = 3'b100;
      endcase
    end
    return g;
  endfunction

  // Phase code for a follower: {upper, lower}.
  function automatic logic [1:0] sync_code(input phase_e ph, input logic on);
    logic [1:0] s;
    s = 2'b00;
    if (on) begin
      case (ph)
        PH_G1:   s = 2'b10;
        PH_G2:   s = 2'b01;
        default: s = 2'b11;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/vfd_prescaler.sv
module vfd_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/vfd_phase_seq.sv
module vfd_phase_seq
  import vfd_mux_pkg::*;
#(
  parameter int PH_BITS = 10,
  parameter int BLANK   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               duplex_i,
  output logic [PH_BITS-1:0] bit_o,
  output phase_e             phase_o,
  output logic               phase_end_o,
  output logic               grid_win_o
);
  localparam logic [PH_BITS-1:0] BIT_LAST = '1;
  localparam logic [PH_BITS-1:0] GRID_ON  = PH_BITS'((1 << PH_BITS) - BLANK);

  logic [PH_BITS-1:0] bit_q;
  phase_e             phase_q;

  assign phase_end_o = tick_i && (bit_q == BIT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q   <= '0;
      phase_q <= PH_G1;
    end else if (tick_i) begin
      bit_q <= bit_q + 1'b1;
      if (phase_end_o) phase_q <= next_phase(phase_q, duplex_i);
    end
  end

  assign bit_o      = bit_q;
  assign phase_o    = phase_q;
  assign grid_win_o = (bit_q < GRID_ON);
endmodule

// File: rtl/vfd_dim_gate.sv
module vfd_dim_gate #(
  parameter int DIM_W = 10,
  parameter int BLANK = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIM_W-1:0] dim_i,
  input  logic [DIM_W-1:0] bit_i,
  output logic [DIM_W-1:0] duty_o,
  output logic             win_o
);
  localparam logic [DIM_W-1:0] DUTY_MAX = DIM_W'((1 << DIM_W) - BLANK);

  function automatic logic [DIM_W-1:0] clamp_duty(input logic [DIM_W-1:0] v);
    return (v > DUTY_MAX) ? DUTY_MAX : v;
  endfunction

  logic [DIM_W-1:0] duty_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      duty_q <= '0;
    else if (load_i) duty_q <= clamp_duty(dim_i);
  end

  assign duty_o = duty_q;
  assign win_o  = (bit_i < duty_q);
endmodule

// File: rtl/vfd_seg_select.sv
module vfd_seg_select
  import vfd_mux_pkg::*;
#(
  parameter int SEG_W = 32
) (
  input  phase_e           phase_i,
  input  logic             win_i,
  input  logic [SEG_W-1:0] g1_i,
  input  logic [SEG_W-1:0] g2_i,
  input  logic [SEG_W-1:0] g3_i,
  output logic [SEG_W-1:0] seg_o
);
  logic [SEG_W-1:0] pick;

  always_comb begin
    case (phase_i)
      PH_G1:   pick = g1_i;
      PH_G2:   pick = g2_i;
      default: pick = g3_i;
    endcase
  end

  assign seg_o = win_i ? pick : '0;
endmodule

// File: rtl/vfd_mux_timer.sv
module vfd_mux_timer
  import vfd_mux_pkg::*;
#(
  parameter int SEG_W = 32,
  parameter int DIM_W = 10,
  parameter int DIV   = 4,
  parameter int BLANK = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             duplex_i,
  input  logic [DIM_W-1:0] dim_i,
  input  logic [SEG_W-1:0] seg_g1_i,
  input  logic [SEG_W-1:0] seg_g2_i,
  input  logic [SEG_W-1:0] seg_g3_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [2:0]       grid_o,
  output logic             dim_pulse_o,
  output logic             sync1_o,
  output logic             sync2_o
);
  // Named internal events, visible to the bound checker.
  logic             tick;
  logic [DIM_W-1:0] bit_pos;
  phase_e           phase;
  logic             phase_end;
  logic             grid_win;
  logic [DIM_W-1:0] duty;
  logic             dim_win;
  logic [1:0]       sync_w;

  vfd_prescaler #(.DIV(DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  vfd_phase_seq #(.PH_BITS(DIM_W), .BLANK(BLANK)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .duplex_i    (duplex_i),
    .bit_o       (bit_pos),
    .phase_o     (phase),
    .phase_end_o (phase_end),
    .grid_win_o  (grid_win)
  );

  vfd_dim_gate #(.DIM_W(DIM_W), .BLANK(BLANK)) u_dim (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (phase_end),
    .dim_i  (dim_i),
    .bit_i  (bit_pos),
    .duty_o (duty),
    .win_o  (dim_win)
  );

  vfd_seg_select #(.SEG_W(SEG_W)) u_sel (
    .phase_i (phase),
    .win_i   (dim_win),
    .g1_i    (seg_g1_i),
    .g2_i    (seg_g2_i),
    .g3_i    (seg_g3_i),
    .seg_o   (seg_o)
  );

  assign grid_o      = grid_code(phase, grid_win);
  assign sync_w      = sync_code(phase, grid_win);
  assign sync1_o     = sync_w[1];
  assign sync2_o     = sync_w[0];
  assign dim_pulse_o = dim_win;
endmodule

// File: rtl/vfd_mux_timer_chk.sv
module vfd_mux_timer_chk #(
  parameter int SEG_W = 32,
  parameter int DIM_W = 10,
  parameter int BLANK = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             duplex_i,
  input logic             tick,
  input logic             phase_end,
  input logic [1:0]       phase,
  input logic [DIM_W-1:0] duty,
  input logic [SEG_W-1:0] seg_o,
  input logic [2:0]       grid_o,
  input logic             dim_pulse_o,
  input logic             sync1_o,
  input logic             sync2_o
);
  localparam logic [DIM_W-1:0] DUTY_MAX = DIM_W'((1 << DIM_W) - BLANK);

  a_r2_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r3_grid_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grid_o));

  a_r4_duplex_skips_g3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end && duplex_i) |=> (phase != 2'd2));

  a_r5_duty_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    duty <= DUTY_MAX);

  a_r6_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_end |=> $stable(duty));

  a_r7_seg_dark_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !dim_pulse_o |-> (seg_o == '0));

  a_r8_pulse_inside_grid: assert property (@(posedge clk) disable iff (!rst_n)
    dim_pulse_o |-> (grid_o != 3'b000));

  a_r9_sync_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (grid_o == 3'b000) |-> (!sync1_o && !sync2_o));

  a_r9_sync_live: assert property (@(posedge clk) disable iff (!rst_n)
    (grid_o != 3'b000) |-> (sync1_o || sync2_o));
endmodule

bind vfd_mux_timer vfd_mux_timer_chk #(.SEG_W(SEG_W), .DIM_W(DIM_W), .BLANK(BLANK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .duplex_i    (duplex_i),
  .tick        (tick),
  .phase_end   (phase_end),
  .phase       (phase),
  .duty        (duty),
  .seg_o       (seg_o),
  .grid_o      (grid_o),
  .dim_pulse_o (dim_pulse_o),
  .sync1_o     (sync1_o),
  .sync2_o     (sync2_o)
);

// File: tb/vfd_mux_timer_test.sv
`timescale 1ns/1ps
module vfd_mux_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        duplex = 1'b0;
  logic [9:0]  dim = 10'd0;
  logic [31:0] lat [3];
  logic [31:0] seg;
  logic [2:0]  grid;
  logic        dpulse, s1, s2;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    int ph;
    bit gwin;
    bit win;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  vfd_mux_timer uut (
    .clk (clk), .rst_n (rst_n), .duplex_i (duplex), .dim_i (dim),
    .seg_g1_i (lat[0]), .seg_g2_i (lat[1]), .seg_g3_i (lat[2]),
    .seg_o (seg), .grid_o (grid), .dim_pulse_o (dpulse),
    .sync1_o (s1), .sync2_o (s2)
  );

  // Reference model, written from the requirements.
  int m_clk, m_bit, m_ph, m_duty;
  always @(posedge clk) begin
    exp_t e;
    if (!rst_n) begin
      m_clk = 0; m_bit = 0; m_ph = 0; m_duty = 0;
    end else begin
      m_clk++;
      if (m_clk == 4) begin                 // R2: one bit time per 4 clocks
        m_clk = 0;
        if (m_bit == 1023) begin            // R2: phase of 1024 bit times
          m_bit = 0;
          if (m_ph == 0) m_ph = 1;          // R4: phase order
          else if (m_ph == 1) m_ph = duplex ? 0 : 2;
          else m_ph = 0;
          m_duty = (dim > 10'd1016) ? 1016 : int'(dim);  // R5, R6
        end else m_bit++;
      end
    end
    e.ph = m_ph;
    e.gwin = (m_bit < 1016);                // R3
    e.win = (m_bit < m_duty);               // R5
    q.push_back(e);
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: pops expected items and compares away from the clock edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [2:0]  eg;
      logic [1:0]  es;
      logic [31:0] eseg;
      e = q.pop_front();
      eg = e.gwin ? 3'(1 << e.ph) : 3'b000;
      es = !e.gwin ? 2'b00 : (e.ph == 0) ? 2'b10 : (e.ph == 1) ? 2'b01 : 2'b11;
      eseg = e.win ? lat[e.ph] : 32'h0;
      cmp("R3 R4 grid", {29'd0, grid}, {29'd0, eg});
      cmp("R7 segments", seg, eseg);
      cmp("R8 dim pulse", {31'd0, dpulse}, {31'd0, e.win});
      cmp("R9 sync", {30'd0, s1, s2}, {30'd0, es});
    end
  end

  task automatic drive(input logic dup, input logic [9:0] d,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    @(posedge clk); #1;
    duplex = dup; dim = d; lat[0] = a; lat[1] = b; lat[2] = c;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    lat[0] = 32'hA5A5_0F0F; lat[1] = 32'h1234_5678; lat[2] = 32'hFFFF_0001;
    dim = 10'd700;
    wait_clk(5);
    @(negedge clk);
    // R1: reset state
    cmp("R1 reset grid", {29'd0, grid}, 32'd1);
    cmp("R1 reset seg", seg, 32'd0);
    cmp("R1 reset pulse", {31'd0, dpulse}, 32'd0);
    #1 rst_n = 1'b1;
    wait_clk(100);
    @(negedge clk);
    cmp("R1 first phase dark", seg, 32'd0);
    // Triplex, mid duty; mid-phase change tests R6
    drive(1'b0, 10'd300, 32'hA5A5_0F0F, 32'h1234_5678, 32'hFFFF_0001);
    wait_clk(6000);
    drive(1'b0, 10'd1023, 32'hA5A5_0F0F, 32'h1234_5678, 32'hFFFF_0001); // R5 clamp
    wait_clk(5000);
    drive(1'b0, 10'd1, 32'h0000_FFFF, 32'hFFFF_0000, 32'h8000_0001);
    wait_clk(7000);
    drive(1'b0, 10'd1016, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'hCAFE_0000);
    wait_clk(9000);
    // Duplex
    drive(1'b1, 10'd512, 32'h1111_1111, 32'h2222_2222, 32'h4444_4444);
    wait_clk(10000);
    drive(1'b1, 10'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wait_clk(6000);
    drive(1'b1, 10'd1017, 32'h5555_AAAA, 32'hAAAA_5555, 32'hFFFF_FFFF);
    wait_clk(9000);
    // Back to triplex
    drive(1'b0, 10'd64, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h3C3C_3C3C);
    wait_clk(14000);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule